// File: doc/BRIEF.md
# Data-Stationary Pipeline Control Decoder

This block produces the control signals for a five-stage processor pipeline made up of fetch, decode, operand read, execute and result write. It does not issue time-shifted controls from one central decoder. Each accepted instruction word enters a chain of stage registers, and its opcode and register fields move down that chain together with the instruction's data. The operand-read, execute and result-write stages each have their own small decoder. Each of these decoders turns the opcode held in its own stage register into that stage's controls. The result-write decoder also takes a datapath flag into account. Fetch and decode behave the same way for every instruction, so they produce no opcode-dependent controls.

Two instructions, complex multiply and square distance, stay in execute for two cycles. During the first of these cycles the earlier stages hold, fetch is told that no word is being taken, and a bubble enters result write. An external stall freezes fetch through execute and also sends a bubble to result write. A flush turns the fetch and decode slots into no-operation.

Top module: `dstat_pipe_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every stage holds an invalid no-operation slot. All control outputs are zero and `fetch_rdy_o` is 1.
- R2: The instruction word is {opcode[19:12], rd[11:8], rs1[7:4], rs2[3:0]}. The block takes the word on a rising edge when `fetch_rdy_o` is 1. Without stalls, the word's operand-read controls appear after the 3rd edge counted from that capture edge, its execute controls after the 4th, and its result-write controls after the 5th (the 6th for a two-cycle instruction).
- R3: Operand read sets `rd_en_o` (bit0 = rs1 port, bit1 = rs2 port) to 11 for ADD 0x00, SUB 0x01, AND 0x02, CMP 0x05, CMUL 0x10 and SQD 0x11, and to 01 for MOV 0x03 and CMOV 0x04. `rs1_o` and `rs2_o` carry the address when their port is enabled and are 0 otherwise.
- R4: `ex_alu_o` encodes the operation as NONE=0, ADD=1, SUB=2 (also for CMP), AND=3, PASS=4 (MOV and CMOV), CMUL=5 and SQD=6. For a single-cycle instruction, `ex_last_o` is 1 during its one execute cycle.
- R5: Result write asserts `wb_we_o` with `wb_rd_o` = rd for ADD, SUB, AND, MOV, CMUL and SQD. CMP never writes. CMOV writes only if `flag_i` is 1 in its result-write cycle. `wb_rd_o` is 0 whenever `wb_we_o` is 0.
- R6: `wb_flg_o` is a flag update mask ordered {carry, overflow, zero, negative}. It is 1111 for ADD, SUB and CMP, 0011 for AND, 0010 for SQD, and 0000 otherwise.
- R7: CMUL and SQD occupy execute for two cycles. In the first, `ex_last_o` is 0 and `fetch_rdy_o` is 0. In the second, `ex_last_o` is 1 and result write holds a bubble. Instructions behind them are delayed one cycle and are not lost.
- R8: While `stall_i` is 1, `fetch_rdy_o` is 0, the fetch through execute slots keep their contents, and result write receives a bubble. No instruction is lost.
- R9: `flush_i` at an edge turns the fetch and decode slots into invalid no-operation, so the word presented at that edge is dropped. The slot moving into operand read at that edge is not affected.
- R10: A word taken while `instr_vld_i` is 0, the no-operation opcode 0xFF, and any opcode outside the set above produce no control at any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 20 | Fetched instruction word |
| instr_vld_i | input | 1 | instr_i holds a real instruction |
| stall_i | input | 1 | Hold fetch through execute, send a bubble to result write |
| flush_i | input | 1 | Clear the fetch and decode slots |
| flag_i | input | 1 | Datapath condition flag, used by result write |
| fetch_rdy_o | output | 1 | The word on instr_i is taken at the next edge |
| rd_en_o | output | 2 | Operand read port enables {rs2, rs1} |
| rs1_o | output | 4 | Operand read address, port rs1 |
| rs2_o | output | 4 | Operand read address, port rs2 |
| ex_alu_o | output | 3 | Execute operation select |
| ex_last_o | output | 1 | Final execute cycle of a valid instruction |
| wb_we_o | output | 1 | Register write enable |
| wb_rd_o | output | 4 | Destination register |
| wb_flg_o | output | 4 | Flag update mask {C,V,Z,N} |

## Verification
Each opcode is sent alone, followed by idle words, and every stage's controls are checked in the cycle that instruction reaches the stage. This exposes a decode error in one stage that the other stages would hide. CMOV is sent with the flag both high and low, to separate conditional writing from fixed writing. Field values of all ones and all zeros check the field slicing. A two-cycle instruction followed immediately by two single-cycle ones checks the hold and the bubble, and shows that the younger instructions keep their order and contents. Separate runs of stall, flush, an invalid word that carries a real opcode, and unknown opcodes check that each one suppresses exactly the slots it should.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  parameter int OPC_W = 8;
  parameter int REG_W = 4;
  localparam int INSTR_W = OPC_W + 3 * REG_W;
  localparam int FLG_W = 4;
  localparam int ALU_W = 3;

  localparam int STG_RD = 0;
  localparam int STG_EX = 1;
  localparam int STG_WB = 2;

  localparam int CTRL_RD_W = 2 + 2 * REG_W;
  localparam int CTRL_EX_W = ALU_W + 1;
  localparam int CTRL_WB_W = 1 + REG_W + FLG_W;

  localparam logic [OPC_W-1:0] OPC_ADD  = OPC_W'('h00);
  localparam logic [OPC_W-1:0] OPC_SUB  = OPC_W'('h01);
  localparam logic [OPC_W-1:0] OPC_AND  = OPC_W'('h02);
  localparam logic [OPC_W-1:0] OPC_MOV  = OPC_W'('h03);
  localparam logic [OPC_W-1:0] OPC_CMOV = OPC_W'('h04);
  localparam logic [OPC_W-1:0] OPC_CMP  = OPC_W'('h05);
  localparam logic [OPC_W-1:0] OPC_CMUL = OPC_W'('h10);
  localparam logic [OPC_W-1:0] OPC_SQD  = OPC_W'('h11);
  localparam logic [OPC_W-1:0] OPC_NOP  = '1;

  // flag mask order {C,V,Z,N}
  localparam logic [FLG_W-1:0] FLG_ALL = 4'b1111;
  localparam logic [FLG_W-1:0] FLG_ZN  = 4'b0011;
  localparam logic [FLG_W-1:0] FLG_Z   = 4'b0010;

  typedef enum logic [ALU_W-1:0] {
    ALU_NONE = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_SUB  = 3'd2,
    ALU_AND  = 3'd3,
    ALU_PASS = 3'd4,
    ALU_CMUL = 3'd5,
    ALU_SQD  = 3'd6
  } alu_e;

  typedef struct packed {
    logic             vld;
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
  } slot_t;

  localparam slot_t SLOT_NOP = '{vld: 1'b0, opc: OPC_NOP, rd: '0, rs1: '0, rs2: '0};

  typedef struct packed {
    logic             known;
    logic [1:0]       rd_en;
    alu_e             alu;
    logic             two;
    logic             wr;
    logic             cond;
    logic [FLG_W-1:0] flg;
  } dec_t;

  function automatic dec_t op_decode(input logic [OPC_W-1:0] opc);
    dec_t d;
    d = '0;
    case (opc)
      OPC_ADD:  begin d.known = 1'b1; d.rd_en = 2'b11; d.alu = ALU_ADD;  d.wr = 1'b1; d.flg = FLG_ALL; end
      OPC_SUB:  begin d.known = 1'b1; d.rd_en = 2'b11; d.alu = ALU_SUB;  d.wr = 1'b1; d.flg = FLG_ALL; end
      OPC_AND:  begin d.known = 1'b1; d.rd_en = 2'b11; d.alu = ALU_AND;  d.wr = 1'b1; d.flg = FLG_ZN;  end
      OPC_MOV:  begin d.known = 1'b1; d.rd_en = 2'b01; d.alu = ALU_PASS; d.wr = 1'b1; end
      OPC_CMOV: begin d.known = 1'b1; d.rd_en = 2'b01; d.alu = ALU_PASS; d.wr = 1'b1; d.cond = 1'b1; end
      OPC_CMP:  begin d.known = 1'b1; d.rd_en = 2'b11; d.alu = ALU_SUB;  d.flg = FLG_ALL; end
      OPC_CMUL: begin d.known = 1'b1; d.rd_en = 2'b11; d.alu = ALU_CMUL; d.wr = 1'b1; d.two = 1'b1; end
      OPC_SQD:  begin d.known = 1'b1; d.rd_en = 2'b11; d.alu = ALU_SQD;  d.wr = 1'b1; d.two = 1'b1; d.flg = FLG_Z; end
      default:  ;
    endcase
    return d;
  endfunction

  function automatic logic op_two(input logic [OPC_W-1:0] opc);
    dec_t d;
    d = op_decode(opc);
    return d.two;
  endfunction
endpackage

// File: rtl/dsp_slot_reg.sv
module dsp_slot_reg
  import dsp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  kill_i,
  input  slot_t d_i,
  output slot_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= SLOT_NOP;
    else if (kill_i) q_o <= SLOT_NOP;
    else if (load_i) q_o <= d_i;
  end

  // R9
  kill_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> (!q_o.vld && q_o.opc == OPC_NOP));

  // R8
  hold_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!kill_i && !load_i) |=> $stable(q_o));
endmodule

// File: rtl/dsp_ex_stage.sv
module dsp_ex_stage
  import dsp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  stall_i,
  input  slot_t slot_i,
  output slot_t slot_o,
  output logic  phase_o,
  output logic  busy_o
);
  slot_t slot_q;
  logic  phase_q;

  // first cycle of a two-cycle op: the front must hold
  assign busy_o  = slot_q.vld & op_two(slot_q.opc) & ~phase_q;
  assign slot_o  = slot_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= SLOT_NOP;
      phase_q <= 1'b0;
    end else if (!stall_i) begin
      if (busy_o) begin
        phase_q <= 1'b1;
      end else begin
        slot_q  <= slot_i;
        phase_q <= 1'b0;
      end
    end
  end

  // R7
  two_cyc_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !stall_i) |=> (phase_o && $stable(slot_o)));

  // R7
  phase_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o |-> (slot_o.vld && op_two(slot_o.opc)));

  // R8
  ex_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(slot_o) && $stable(phase_o)));
endmodule

// File: rtl/dsp_stage_dec.sv
module dsp_stage_dec
  import dsp_pkg::*;
#(
  parameter  int STAGE = STG_RD,
  localparam int CW = (STAGE == STG_RD) ? CTRL_RD_W :
                      (STAGE == STG_EX) ? CTRL_EX_W : CTRL_WB_W
) (
  input  slot_t         slot_i,
  input  logic          last_i,
  input  logic          flag_i,
  output logic [CW-1:0] ctrl_o
);
  dec_t dec;
  logic act;

  assign dec = op_decode(slot_i.opc);
  assign act = slot_i.vld & dec.known;

  if (STAGE == STG_RD) begin : g_rd
    logic [1:0] en;
    logic       unused_rd;
    assign en     = act ? dec.rd_en : 2'b00;
    assign ctrl_o = {en,
                     en[0] ? slot_i.rs1 : {REG_W{1'b0}},
                     en[1] ? slot_i.rs2 : {REG_W{1'b0}}};
    assign unused_rd = ^{last_i, flag_i, slot_i.rd, dec.alu, dec.two, dec.wr, dec.cond, dec.flg};
  end else if (STAGE == STG_EX) begin : g_ex
    logic unused_ex;
    assign ctrl_o    = {act ? dec.alu : ALU_NONE, act & (~dec.two | last_i)};
    assign unused_ex = ^{flag_i, slot_i.rd, slot_i.rs1, slot_i.rs2, dec.rd_en, dec.wr, dec.cond, dec.flg};
  end else begin : g_wb
    logic we;
    logic unused_wb;
    // conditional write samples the datapath flag in this stage
    assign we        = act & dec.wr & (~dec.cond | flag_i);
    assign ctrl_o    = {we, we ? slot_i.rd : {REG_W{1'b0}}, act ? dec.flg : {FLG_W{1'b0}}};
    assign unused_wb = ^{last_i, slot_i.rs1, slot_i.rs2, dec.rd_en, dec.alu, dec.two};
  end

  // R10
  always_comb begin
    if (slot_i.vld === 1'b0) idle_ctrl_chk: assert (ctrl_o == '0);
  end
endmodule

// File: rtl/dstat_pipe_ctrl.sv
module dstat_pipe_ctrl
  import dsp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               instr_vld_i,
  input  logic               stall_i,
  input  logic               flush_i,
  input  logic               flag_i,
  output logic               fetch_rdy_o,
  output logic [1:0]         rd_en_o,
  output logic [REG_W-1:0]   rs1_o,
  output logic [REG_W-1:0]   rs2_o,
  output logic [ALU_W-1:0]   ex_alu_o,
  output logic               ex_last_o,
  output logic               wb_we_o,
  output logic [REG_W-1:0]   wb_rd_o,
  output logic [FLG_W-1:0]   wb_flg_o
);
  localparam int FRONT_N = 3;  // fetch, decode, operand read
  localparam int FLUSH_N = 2;  // fetch, decode

  slot_t in_slot;
  slot_t fr_d [FRONT_N];
  slot_t fr_q [FRONT_N];
  slot_t ex_slot;
  slot_t wb_slot;
  logic  ex_phase;
  logic  ex_busy;
  logic  front_hold;

  logic [CTRL_RD_W-1:0] rd_ctrl;
  logic [CTRL_EX_W-1:0] ex_ctrl;
  logic [CTRL_WB_W-1:0] wb_ctrl;

  always_comb begin
    in_slot = SLOT_NOP;
    if (instr_vld_i) begin
      in_slot.vld = 1'b1;
      in_slot.opc = instr_i[INSTR_W-1 -: OPC_W];
      in_slot.rd  = instr_i[3*REG_W-1 -: REG_W];
      in_slot.rs1 = instr_i[2*REG_W-1 -: REG_W];
      in_slot.rs2 = instr_i[REG_W-1:0];
    end
  end

  assign front_hold  = stall_i | ex_busy;
  assign fetch_rdy_o = ~front_hold;

  for (genvar i = 0; i < FRONT_N; i++) begin : g_front
    if (i == 0) begin : g_head
      assign fr_d[i] = in_slot;
    end else begin : g_link
      assign fr_d[i] = fr_q[i-1];
    end
    dsp_slot_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (~front_hold),
      .kill_i (flush_i && (i < FLUSH_N)),
      .d_i    (fr_d[i]),
      .q_o    (fr_q[i])
    );
  end

  dsp_ex_stage u_ex (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stall_i (stall_i),
    .slot_i  (fr_q[FRONT_N-1]),
    .slot_o  (ex_slot),
    .phase_o (ex_phase),
    .busy_o  (ex_busy)
  );

  // result write always advances; a held front becomes a bubble here
  dsp_slot_reg u_wb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (1'b1),
    .kill_i (front_hold),
    .d_i    (ex_slot),
    .q_o    (wb_slot)
  );

  dsp_stage_dec #(.STAGE(STG_RD)) u_dec_rd (
    .slot_i (fr_q[FRONT_N-1]),
    .last_i (1'b0),
    .flag_i (flag_i),
    .ctrl_o (rd_ctrl)
  );

  dsp_stage_dec #(.STAGE(STG_EX)) u_dec_ex (
    .slot_i (ex_slot),
    .last_i (ex_phase),
    .flag_i (flag_i),
    .ctrl_o (ex_ctrl)
  );

  dsp_stage_dec #(.STAGE(STG_WB)) u_dec_wb (
    .slot_i (wb_slot),
    .last_i (1'b0),
    .flag_i (flag_i),
    .ctrl_o (wb_ctrl)
  );

  assign {rd_en_o, rs1_o, rs2_o}      = rd_ctrl;
  assign {ex_alu_o, ex_last_o}        = ex_ctrl;
  assign {wb_we_o, wb_rd_o, wb_flg_o} = wb_ctrl;

  // R7
  bubble_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_busy && !stall_i) |=> (!wb_we_o && wb_flg_o == '0 && ex_last_o));

  // R8
  stall_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(rd_en_o) && $stable(rs1_o) && $stable(rs2_o)));

  // R2
  wb_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !front_hold |=> (wb_slot == $past(ex_slot)));

  // R9
  flush_front_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!fr_q[0].vld && !fr_q[1].vld));
endmodule

// File: tb/sim_dstat_pipe_ctrl.sv
module sim_dstat_pipe_ctrl;
  import dsp_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 12;
  localparam int WD_CYCLES = 5000;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic             flag;
    logic [1:0]       en;
    logic [ALU_W-1:0] alu;
    logic             two;
    logic             we;
    logic [FLG_W-1:0] flg;
  } vec_t;

  // opc rd rs1 rs2 flag | en alu two we flg
  localparam vec_t VECS [N_VEC] = '{
    '{8'h00, 4'h1, 4'h2, 4'h3, 1'b0, 2'b11, 3'd1, 1'b0, 1'b1, 4'hF},
    '{8'h01, 4'h4, 4'h5, 4'h6, 1'b0, 2'b11, 3'd2, 1'b0, 1'b1, 4'hF},
    '{8'h02, 4'h7, 4'h8, 4'h9, 1'b1, 2'b11, 3'd3, 1'b0, 1'b1, 4'h3},
    '{8'h03, 4'hA, 4'hB, 4'hC, 1'b0, 2'b01, 3'd4, 1'b0, 1'b1, 4'h0},
    '{8'h04, 4'hD, 4'hE, 4'h1, 1'b1, 2'b01, 3'd4, 1'b0, 1'b1, 4'h0},
    '{8'h04, 4'hD, 4'hE, 4'h1, 1'b0, 2'b01, 3'd4, 1'b0, 1'b0, 4'h0},
    '{8'h05, 4'h3, 4'h2, 4'h1, 1'b1, 2'b11, 3'd2, 1'b0, 1'b0, 4'hF},
    '{8'h10, 4'h5, 4'h6, 4'h7, 1'b0, 2'b11, 3'd5, 1'b1, 1'b1, 4'h0},
    '{8'h11, 4'h8, 4'h9, 4'hA, 1'b0, 2'b11, 3'd6, 1'b1, 1'b1, 4'h2},
    '{8'hFF, 4'h1, 4'h2, 4'h3, 1'b0, 2'b00, 3'd0, 1'b0, 1'b0, 4'h0},
    '{8'h7E, 4'h4, 4'h5, 4'h6, 1'b1, 2'b00, 3'd0, 1'b0, 1'b0, 4'h0},
    '{8'h00, 4'hF, 4'hF, 4'h0, 1'b0, 2'b11, 3'd1, 1'b0, 1'b1, 4'hF}
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic [INSTR_W-1:0] instr;
  logic               vld, stall, flush, flag;
  logic               fetch_rdy;
  logic [1:0]         rd_en;
  logic [REG_W-1:0]   rs1, rs2, wb_rd;
  logic [ALU_W-1:0]   ex_alu;
  logic               ex_last, wb_we;
  logic [FLG_W-1:0]   wb_flg;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dstat_pipe_ctrl u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .instr_i     (instr),
    .instr_vld_i (vld),
    .stall_i     (stall),
    .flush_i     (flush),
    .flag_i      (flag),
    .fetch_rdy_o (fetch_rdy),
    .rd_en_o     (rd_en),
    .rs1_o       (rs1),
    .rs2_o       (rs2),
    .ex_alu_o    (ex_alu),
    .ex_last_o   (ex_last),
    .wb_we_o     (wb_we),
    .wb_rd_o     (wb_rd),
    .wb_flg_o    (wb_flg)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic put(input logic [OPC_W-1:0] opc, input logic [REG_W-1:0] rd,
                     input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
    instr = {opc, rd, a, b};
    vld   = 1'b1;
  endtask

  task automatic idle_in();
    instr = '0;
    vld   = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    vec_t v;
    rst_n = 1'b0; instr = '0; vld = 1'b0; stall = 1'b0; flush = 1'b0; flag = 1'b0;
    repeat (2) tick();
    // R1 during reset
    chk("R1 fetch_rdy", 32'(fetch_rdy), 32'd1);
    chk("R1 rd_en", 32'(rd_en), 32'd0);
    chk("R1 ex_alu", 32'(ex_alu), 32'd0);
    chk("R1 wb_we", 32'(wb_we), 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 ex_last after release", 32'(ex_last), 32'd0);
    chk("R1 wb_flg after release", 32'(wb_flg), 32'd0);

    // table walk: one instruction at a time, each stage checked on arrival
    for (int i = 0; i < N_VEC; i++) begin
      v = VECS[i];
      put(v.opc, v.rd, v.rs1, v.rs2);
      flag = v.flag;
      tick(); idle_in();
      tick();
      tick();
      chk($sformatf("R2 R3 v%0d rd_en", i), 32'(rd_en), 32'(v.en));
      chk($sformatf("R3 v%0d rs1", i), 32'(rs1), v.en[0] ? 32'(v.rs1) : 32'd0);
      chk($sformatf("R3 v%0d rs2", i), 32'(rs2), v.en[1] ? 32'(v.rs2) : 32'd0);
      tick();
      chk($sformatf("R4 v%0d ex_alu", i), 32'(ex_alu), 32'(v.alu));
      chk($sformatf("R4 R10 v%0d ex_last", i), 32'(ex_last),
          v.two ? 32'd0 : 32'(v.alu != 3'd0));
      chk($sformatf("R7 v%0d fetch_rdy", i), 32'(fetch_rdy), v.two ? 32'd0 : 32'd1);
      if (v.two) begin
        tick();
        chk($sformatf("R7 v%0d ex_last 2nd", i), 32'(ex_last), 32'd1);
        chk($sformatf("R7 v%0d wb bubble", i), 32'(wb_we), 32'd0);
      end
      tick();
      chk($sformatf("R5 v%0d wb_we", i), 32'(wb_we), 32'(v.we));
      chk($sformatf("R5 v%0d wb_rd", i), 32'(wb_rd), v.we ? 32'(v.rd) : 32'd0);
      chk($sformatf("R6 v%0d wb_flg", i), 32'(wb_flg), 32'(v.flg));
      tick();
      tick();
    end
    flag = 1'b0;

    // R7 two-cycle op followed at once by two single-cycle ops
    put(OPC_CMUL, 4'h1, 4'h2, 4'h3);
    tick(); put(OPC_ADD, 4'h2, 4'h4, 4'h5);
    tick(); put(OPC_MOV, 4'h3, 4'h6, 4'h0);
    tick(); idle_in();
    tick();
    chk("R7 hold fetch_rdy", 32'(fetch_rdy), 32'd0);
    chk("R7 first ex_last", 32'(ex_last), 32'd0);
    chk("R7 first ex_alu", 32'(ex_alu), 32'd5);
    tick();
    chk("R7 second ex_last", 32'(ex_last), 32'd1);
    chk("R7 held rd_en", 32'(rd_en), 32'd3);
    chk("R7 held rs1", 32'(rs1), 32'd4);
    chk("R7 bubble wb_we", 32'(wb_we), 32'd0);
    tick();
    chk("R7 cmul wb_rd", 32'(wb_rd), 32'd1);
    chk("R7 add in ex", 32'(ex_alu), 32'd1);
    tick();
    chk("R7 add wb_rd", 32'(wb_rd), 32'd2);
    chk("R7 add wb_flg", 32'(wb_flg), 32'hF);
    tick();
    chk("R7 mov wb_rd", 32'(wb_rd), 32'd3);
    chk("R7 mov wb_we", 32'(wb_we), 32'd1);
    repeat (3) tick();

    // R9 flush: oldest survives, next two are dropped
    put(OPC_ADD, 4'h4, 4'h1, 4'h1);
    tick(); put(OPC_ADD, 4'h5, 4'h1, 4'h1);
    tick(); put(OPC_MOV, 4'h6, 4'h1, 4'h0); flush = 1'b1;
    tick(); idle_in(); flush = 1'b0;
    tick();
    chk("R9 flushed slot rd_en", 32'(rd_en), 32'd0);
    tick();
    chk("R9 survivor wb_we", 32'(wb_we), 32'd1);
    chk("R9 survivor wb_rd", 32'(wb_rd), 32'd4);
    tick();
    chk("R9 dropped wb_we a", 32'(wb_we), 32'd0);
    tick();
    chk("R9 dropped wb_we b", 32'(wb_we), 32'd0);
    repeat (2) tick();

    // R8 external stall with an instruction in execute
    put(OPC_ADD, 4'h7, 4'h1, 4'h2);
    tick(); idle_in();
    repeat (3) tick();
    stall = 1'b1;
    #1;
    chk("R8 fetch_rdy low", 32'(fetch_rdy), 32'd0);
    tick();
    chk("R8 bubble wb_we", 32'(wb_we), 32'd0);
    chk("R8 ex held", 32'(ex_alu), 32'd1);
    tick();
    chk("R8 bubble wb_we 2", 32'(wb_we), 32'd0);
    chk("R8 ex held 2", 32'(ex_alu), 32'd1);
    stall = 1'b0;
    tick();
    chk("R8 released wb_we", 32'(wb_we), 32'd1);
    chk("R8 released wb_rd", 32'(wb_rd), 32'd7);
    repeat (2) tick();

    // R10 real opcode presented with instr_vld_i low
    instr = {OPC_ADD, 4'h9, 4'h1, 4'h2};
    vld   = 1'b0;
    tick(); idle_in();
    tick();
    tick();
    chk("R10 invalid rd_en", 32'(rd_en), 32'd0);
    tick();
    chk("R10 invalid ex_alu", 32'(ex_alu), 32'd0);
    tick();
    chk("R10 invalid wb_we", 32'(wb_we), 32'd0);
    chk("R10 invalid wb_flg", 32'(wb_flg), 32'd0);

    summary();
  end
endmodule